// File: doc/BRIEF.md
# Power-Down Output Gating Controller

This block keeps the global power-down control bit for the digital core of an audio amplifier. While power-down is active, it forces every output of the core into a defined safe state. Each output group has its own rule for that state:

- The power PWM stage is released to high impedance.
- The logic-level PWM pins either hold low or float, as a select bit chooses.
- The auxiliary serial port may keep its clocks running. It does so only when it is enabled, sourced from the serial input, and fed with valid clocks.
- The delay serial output may carry the raw serial input data. It does so under a stricter set of conditions.

The power-down bit comes out of reset set, so the core starts silent and software must clear it. Clearing it does not release the outputs at once. A start-up phase of a fixed, parameterised number of cycles comes first. During that phase the PWM drivers are enabled but held at zero, so that no click is produced. After it, the normal PWM streams are passed through. Setting the bit again at any point takes the outputs back to the safe state on the clock edge that records the write.

Top module: `pwr_gate_ctrl`

## Requirements
- R1: After reset the power-down bit reads as set and every output shows the power-down state.
- R2: While powered down, every power PWM enable is 0 and every power PWM data bit is 0.
- R3: While powered down with hiz_sel = 1, every logic PWM enable is 1 and its data is 0. With hiz_sel = 0, every logic PWM enable is 0.
- R4: While powered down, aux_sdout is 0 whatever aux_sdout_in carries.
- R5: While powered down, aux_lrck and aux_sclk follow aux_lrck_in and aux_sclk_in only when aux_en = 1, adc_src = 0, sclk_ok = 1 and lrck_ok = 1. Otherwise both are 0.
- R6: While powered down, dly_sdout follows ser_sdata only when all of these hold: aux_en = 1, dly_cfg = 2'b01, adc_src = 0, sclk_ok = 1, lrck_ok = 1 and sdata_ok = 1. Otherwise it is 0. The codes 2'b00, 2'b10 and 2'b11 always give 0.
- R7: A write of 0 to the power-down bit starts a start-up phase on that edge, and the phase lasts exactly STARTUP_CYCLES clock cycles. During it, all power and logic PWM enables are 1 and all their data bits are 0, while the auxiliary and delay outputs pass their normal inputs.
- R8: After the start-up phase, every PWM enable is 1, each PWM data bit follows its input, and aux_sdout, aux_lrck, aux_sclk and dly_sdout follow their normal inputs.
- R9: A write of 1 during start-up or normal running restores the power-down outputs on the same edge that captures the write.
- R10: Without a write, the power-down bit keeps its value. Changes to configuration, validity flags or data inputs never move the block between power-down and running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_we | input | 1 | Write strobe for the power-down bit |
| pd_wdata | input | 1 | Value written to the power-down bit |
| hiz_sel | input | 1 | Power-down mode of logic PWM pins: 1 = hold low, 0 = float |
| aux_en | input | 1 | Auxiliary port enable |
| adc_src | input | 1 | Source select: 1 = ADC path, 0 = serial input |
| dly_cfg | input | 2 | Delay port configuration, 2'b01 = serial delay interface |
| sclk_ok | input | 1 | Valid bit clock detected at the serial input |
| lrck_ok | input | 1 | Valid frame clock detected at the serial input |
| sdata_ok | input | 1 | Valid data detected at the serial input |
| ser_sdata | input | 1 | Unprocessed serial input data |
| pwr_pwm_in | input | N_CH | Normal power PWM stream |
| lgc_pwm_in | input | N_CH | Normal logic PWM stream |
| aux_sdout_in | input | 1 | Normal auxiliary serial data |
| aux_lrck_in | input | 1 | Auxiliary frame clock from the core |
| aux_sclk_in | input | 1 | Auxiliary bit clock from the core |
| dly_sdout_in | input | 1 | Normal delay serial data |
| pwr_pwm_oe | output | N_CH | Power PWM output enables |
| pwr_pwm_o | output | N_CH | Power PWM output data |
| lgc_pwm_oe | output | N_CH | Logic PWM output enables |
| lgc_pwm_o | output | N_CH | Logic PWM output data |
| aux_sdout | output | 1 | Auxiliary serial data out |
| aux_lrck | output | 1 | Auxiliary frame clock out |
| aux_sclk | output | 1 | Auxiliary bit clock out |
| dly_sdout | output | 1 | Delay serial data out |

## Verification
Each internal state shows at the ports in the cycle it holds.

- A state register stuck in or out of power-down shows on the power PWM enables right after the edge that captured the write.
- A start-up counter with the wrong limit shows as an early or late first non-zero PWM data bit, measured against the write edge, to within one cycle.
- A wrong condition for the auxiliary clocks or the delay data shows combinationally in power-down as soon as one enable or validity flag is flipped.

The stimulus table therefore walks one flag at a time away from the all-pass case.

// File: rtl/pwr_gate_pkg.sv
package pwr_gate_pkg;

  typedef enum logic [1:0] {
    PG_DOWN    = 2'd0,
    PG_STARTUP = 2'd1,
    PG_RUN     = 2'd2
  } pg_state_e;

  localparam logic [1:0] DLY_CFG_SERIAL = 2'b01;

  // Auxiliary clocks survive power-down only when fed from a live serial input
  function automatic logic aux_clk_keep(input logic aux_en, input logic adc_src,
                                        input logic sclk_ok, input logic lrck_ok);
    return aux_en & ~adc_src & sclk_ok & lrck_ok;
  endfunction

  // Delay output carries raw serial data in power-down only under full validity
  function automatic logic dly_pass(input logic aux_en, input logic [1:0] cfg,
                                    input logic adc_src, input logic sclk_ok,
                                    input logic lrck_ok, input logic sdata_ok);
    return aux_clk_keep(aux_en, adc_src, sclk_ok, lrck_ok) & sdata_ok &
           (cfg == DLY_CFG_SERIAL);
  endfunction

  // Last start-up cycle when the counter reaches limit-1
  function automatic logic startup_last(input int unsigned cnt, input int unsigned limit);
    return (cnt + 1) >= limit;
  endfunction

endpackage

// File: rtl/pwr_gate_reg.sv
module pwr_gate_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_we,
  input  logic pd_wdata,
  output logic pd_q,
  output logic pd_next
);

  // Value the bit takes at the coming edge; the sequencer acts on it directly
  always_comb begin
    pd_next = pd_we ? pd_wdata : pd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q <= 1'b1;
    end else begin
      pd_q <= pd_next;
    end
  end

endmodule

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq
  import pwr_gate_pkg::*;
#(
  parameter int unsigned STARTUP_CYCLES = 16,
  localparam int unsigned CNT_W = (STARTUP_CYCLES < 2) ? 1 : $clog2(STARTUP_CYCLES)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pd_next,
  output pg_state_e state,
  output logic      startup_done
);

  pg_state_e        state_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    startup_done = (state == PG_STARTUP) &&
                   startup_last(int'(unsigned'(cnt_q)), STARTUP_CYCLES);
  end

  always_comb begin
    state_d = state;
    cnt_d   = '0;
    if (pd_next) begin
      state_d = PG_DOWN;
    end else begin
      unique case (state)
        PG_DOWN: begin
          state_d = PG_STARTUP;
        end
        PG_STARTUP: begin
          if (startup_done) begin
            state_d = PG_RUN;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PG_RUN: begin
          state_d = PG_RUN;
        end
        default: begin
          state_d = PG_DOWN;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PG_DOWN;
      cnt_q <= '0;
    end else begin
      state <= state_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/pwr_gate_out.sv
module pwr_gate_out
  import pwr_gate_pkg::*;
#(
  parameter int unsigned N_CH = 4
) (
  input  pg_state_e         state,
  input  logic              hiz_sel,
  input  logic              aux_keep,
  input  logic              dly_keep,
  input  logic              ser_sdata,
  input  logic [N_CH-1:0]   pwr_pwm_in,
  input  logic [N_CH-1:0]   lgc_pwm_in,
  input  logic              aux_sdout_in,
  input  logic              aux_lrck_in,
  input  logic              aux_sclk_in,
  input  logic              dly_sdout_in,
  output logic [N_CH-1:0]   pwr_pwm_oe,
  output logic [N_CH-1:0]   pwr_pwm_o,
  output logic [N_CH-1:0]   lgc_pwm_oe,
  output logic [N_CH-1:0]   lgc_pwm_o,
  output logic              aux_sdout,
  output logic              aux_lrck,
  output logic              aux_sclk,
  output logic              dly_sdout
);

  logic in_down;
  logic in_run;

  always_comb begin
    in_down = (state == PG_DOWN);
    in_run  = (state == PG_RUN);
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    always_comb begin
      // Power stage: float when down, enabled-and-quiet in start-up
      pwr_pwm_oe[ch] = ~in_down;
      pwr_pwm_o[ch]  = in_run & pwr_pwm_in[ch];
      // Logic pins: hold low or float when down per hiz_sel
      lgc_pwm_oe[ch] = in_down ? hiz_sel : 1'b1;
      lgc_pwm_o[ch]  = in_run & lgc_pwm_in[ch];
    end
  end

  always_comb begin
    if (in_down) begin
      aux_sdout = 1'b0;
      aux_lrck  = aux_keep & aux_lrck_in;
      aux_sclk  = aux_keep & aux_sclk_in;
      dly_sdout = dly_keep & ser_sdata;
    end else begin
      aux_sdout = aux_sdout_in;
      aux_lrck  = aux_lrck_in;
      aux_sclk  = aux_sclk_in;
      dly_sdout = dly_sdout_in;
    end
  end

endmodule

// File: rtl/pwr_gate_ctrl.sv
module pwr_gate_ctrl
  import pwr_gate_pkg::*;
#(
  parameter int unsigned N_CH           = 4,
  parameter int unsigned STARTUP_CYCLES = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pd_we,
  input  logic            pd_wdata,
  input  logic            hiz_sel,
  input  logic            aux_en,
  input  logic            adc_src,
  input  logic [1:0]      dly_cfg,
  input  logic            sclk_ok,
  input  logic            lrck_ok,
  input  logic            sdata_ok,
  input  logic            ser_sdata,
  input  logic [N_CH-1:0] pwr_pwm_in,
  input  logic [N_CH-1:0] lgc_pwm_in,
  input  logic            aux_sdout_in,
  input  logic            aux_lrck_in,
  input  logic            aux_sclk_in,
  input  logic            dly_sdout_in,
  output logic [N_CH-1:0] pwr_pwm_oe,
  output logic [N_CH-1:0] pwr_pwm_o,
  output logic [N_CH-1:0] lgc_pwm_oe,
  output logic [N_CH-1:0] lgc_pwm_o,
  output logic            aux_sdout,
  output logic            aux_lrck,
  output logic            aux_sclk,
  output logic            dly_sdout
);

  logic      pd_q;
  logic      pd_next;
  pg_state_e state;
  logic      startup_done;

  // Named internal events, used by the bound checker
  logic st_down;
  logic st_startup;
  logic st_run;
  logic aux_keep;
  logic dly_keep;

  always_comb begin
    st_down    = (state == PG_DOWN);
    st_startup = (state == PG_STARTUP);
    st_run     = (state == PG_RUN);
    aux_keep   = aux_clk_keep(aux_en, adc_src, sclk_ok, lrck_ok);
    dly_keep   = dly_pass(aux_en, dly_cfg, adc_src, sclk_ok, lrck_ok, sdata_ok);
  end

  pwr_gate_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .pd_we    (pd_we),
    .pd_wdata (pd_wdata),
    .pd_q     (pd_q),
    .pd_next  (pd_next)
  );

  pwr_gate_seq #(
    .STARTUP_CYCLES (STARTUP_CYCLES)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .pd_next      (pd_next),
    .state        (state),
    .startup_done (startup_done)
  );

  pwr_gate_out #(
    .N_CH (N_CH)
  ) u_out (
    .state        (state),
    .hiz_sel      (hiz_sel),
    .aux_keep     (aux_keep),
    .dly_keep     (dly_keep),
    .ser_sdata    (ser_sdata),
    .pwr_pwm_in   (pwr_pwm_in),
    .lgc_pwm_in   (lgc_pwm_in),
    .aux_sdout_in (aux_sdout_in),
    .aux_lrck_in  (aux_lrck_in),
    .aux_sclk_in  (aux_sclk_in),
    .dly_sdout_in (dly_sdout_in),
    .pwr_pwm_oe   (pwr_pwm_oe),
    .pwr_pwm_o    (pwr_pwm_o),
    .lgc_pwm_oe   (lgc_pwm_oe),
    .lgc_pwm_o    (lgc_pwm_o),
    .aux_sdout    (aux_sdout),
    .aux_lrck     (aux_lrck),
    .aux_sclk     (aux_sclk),
    .dly_sdout    (dly_sdout)
  );

endmodule

// File: rtl/pwr_gate_ctrl_chk.sv
module pwr_gate_ctrl_chk #(
  parameter int unsigned N_CH           = 4,
  parameter int unsigned STARTUP_CYCLES = 16,
  localparam int unsigned CW = $clog2(STARTUP_CYCLES + 1) + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pd_we,
  input logic            pd_wdata,
  input logic            pd_q,
  input logic            hiz_sel,
  input logic            aux_keep,
  input logic            dly_keep,
  input logic            st_down,
  input logic            st_startup,
  input logic            st_run,
  input logic [N_CH-1:0] pwr_pwm_oe,
  input logic [N_CH-1:0] pwr_pwm_o,
  input logic [N_CH-1:0] lgc_pwm_oe,
  input logic [N_CH-1:0] lgc_pwm_o,
  input logic            aux_sdout,
  input logic            aux_lrck,
  input logic            aux_sclk,
  input logic            dly_sdout
);

  logic [CW-1:0] su_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      su_cnt <= '0;
    end else if (st_startup) begin
      su_cnt <= su_cnt + 1'b1;
    end else begin
      su_cnt <= '0;
    end
  end

  p_pwr_float_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_down |-> (pwr_pwm_oe == '0) && (pwr_pwm_o == '0));

  p_lgc_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_down && hiz_sel) |-> (lgc_pwm_oe == '1) && (lgc_pwm_o == '0));

  p_lgc_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_down && !hiz_sel) |-> (lgc_pwm_oe == '0));

  p_aux_data_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_down |-> !aux_sdout);

  p_aux_clk_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_down && !aux_keep) |-> (!aux_lrck && !aux_sclk));

  p_dly_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_down && !dly_keep) |-> !dly_sdout);

  p_startup_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_startup |-> (pwr_pwm_oe == '1) && (pwr_pwm_o == '0) && (lgc_pwm_o == '0));

  p_startup_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_run && $past(st_startup)) |-> (su_cnt == CW'(STARTUP_CYCLES)));

  p_startup_from_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_startup) |-> $past(st_down));

  p_reenter_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_we && pd_wdata) |=> st_down && (pwr_pwm_oe == '0));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_we |=> $stable(pd_q));

  p_one_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_down, st_startup, st_run}) && (st_down || st_startup || st_run));

endmodule

bind pwr_gate_ctrl pwr_gate_ctrl_chk #(
  .N_CH           (N_CH),
  .STARTUP_CYCLES (STARTUP_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pd_we      (pd_we),
  .pd_wdata   (pd_wdata),
  .pd_q       (pd_q),
  .hiz_sel    (hiz_sel),
  .aux_keep   (aux_keep),
  .dly_keep   (dly_keep),
  .st_down    (st_down),
  .st_startup (st_startup),
  .st_run     (st_run),
  .pwr_pwm_oe (pwr_pwm_oe),
  .pwr_pwm_o  (pwr_pwm_o),
  .lgc_pwm_oe (lgc_pwm_oe),
  .lgc_pwm_o  (lgc_pwm_o),
  .aux_sdout  (aux_sdout),
  .aux_lrck   (aux_lrck),
  .aux_sclk   (aux_sclk),
  .dly_sdout  (dly_sdout)
);

// File: tb/pwr_gate_ctrl_tb_top.sv
module pwr_gate_ctrl_tb_top;

  localparam int unsigned N_CH = 4;
  localparam int unsigned SU   = 16;

  typedef struct packed {
    logic       hiz;
    logic       aen;
    logic       src;
    logic [1:0] cfg;
    logic       sck_ok;
    logic       lrk_ok;
    logic       sd_ok;
    logic       din;
    logic       lin;
    logic       cin;
    logic       e_lgc;
    logic       e_lrck;
    logic       e_sclk;
    logic       e_dly;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,1'b0,2'd1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b1},
    '{1'b0,1'b1,1'b0,2'd1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1, 1'b0,1'b1,1'b1,1'b1},
    '{1'b1,1'b0,1'b0,2'd1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0},
    '{1'b1,1'b1,1'b1,2'd1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0},
    '{1'b1,1'b1,1'b0,2'd2,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b0},
    '{1'b1,1'b1,1'b0,2'd0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b0},
    '{1'b1,1'b1,1'b0,2'd3,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b0},
    '{1'b1,1'b1,1'b0,2'd1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0},
    '{1'b1,1'b1,1'b0,2'd1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0},
    '{1'b1,1'b1,1'b0,2'd1,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b0},
    '{1'b1,1'b1,1'b0,2'd1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b1,1'b0},
    '{1'b0,1'b1,1'b0,2'd1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_we = 1'b0, pd_wdata = 1'b0;
  logic hiz_sel = 1'b1, aux_en = 1'b0, adc_src = 1'b0;
  logic [1:0] dly_cfg = 2'd0;
  logic sclk_ok = 1'b0, lrck_ok = 1'b0, sdata_ok = 1'b0, ser_sdata = 1'b0;
  logic [N_CH-1:0] pwr_pwm_in = '1, lgc_pwm_in = '1;
  logic aux_sdout_in = 1'b1, aux_lrck_in = 1'b1, aux_sclk_in = 1'b1, dly_sdout_in = 1'b1;
  logic [N_CH-1:0] pwr_pwm_oe, pwr_pwm_o, lgc_pwm_oe, lgc_pwm_o;
  logic aux_sdout, aux_lrck, aux_sclk, dly_sdout;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwr_gate_ctrl #(.N_CH(N_CH), .STARTUP_CYCLES(SU)) dut_i (
    .clk(clk), .rst_n(rst_n), .pd_we(pd_we), .pd_wdata(pd_wdata),
    .hiz_sel(hiz_sel), .aux_en(aux_en), .adc_src(adc_src), .dly_cfg(dly_cfg),
    .sclk_ok(sclk_ok), .lrck_ok(lrck_ok), .sdata_ok(sdata_ok), .ser_sdata(ser_sdata),
    .pwr_pwm_in(pwr_pwm_in), .lgc_pwm_in(lgc_pwm_in), .aux_sdout_in(aux_sdout_in),
    .aux_lrck_in(aux_lrck_in), .aux_sclk_in(aux_sclk_in), .dly_sdout_in(dly_sdout_in),
    .pwr_pwm_oe(pwr_pwm_oe), .pwr_pwm_o(pwr_pwm_o), .lgc_pwm_oe(lgc_pwm_oe),
    .lgc_pwm_o(lgc_pwm_o), .aux_sdout(aux_sdout), .aux_lrck(aux_lrck),
    .aux_sclk(aux_sclk), .dly_sdout(dly_sdout)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Power-down picture of the PWM groups with all normal inputs high
  task automatic check_down(input string req);
    check(req, "pwr_oe", 32'(pwr_pwm_oe), 32'd0);
    check(req, "pwr_o", 32'(pwr_pwm_o), 32'd0);
    check(req, "lgc_oe", 32'(lgc_pwm_oe), hiz_sel ? 32'hF : 32'd0);
    check(req, "lgc_o", 32'(lgc_pwm_o), 32'd0);
    check(req, "aux_sdout", 32'(aux_sdout), 32'd0);
  endtask

  task automatic write_pd(input logic v);
    @(negedge clk);
    pd_we = 1'b1;
    pd_wdata = v;
    @(negedge clk);
    pd_we = 1'b0;
  endtask

  task automatic set_all_pass();
    aux_en = 1'b1; adc_src = 1'b0; dly_cfg = 2'd1;
    sclk_ok = 1'b1; lrck_ok = 1'b1; sdata_ok = 1'b1; ser_sdata = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset leaves the block powered down
    check_down("R1");

    // Table walk in power-down: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      hiz_sel = VECS[i].hiz; aux_en = VECS[i].aen; adc_src = VECS[i].src;
      dly_cfg = VECS[i].cfg; sclk_ok = VECS[i].sck_ok; lrck_ok = VECS[i].lrk_ok;
      sdata_ok = VECS[i].sd_ok; ser_sdata = VECS[i].din;
      aux_lrck_in = VECS[i].lin; aux_sclk_in = VECS[i].cin;
      #1;
      check("R2", "pwr_oe", 32'(pwr_pwm_oe), 32'd0);
      check("R3", "lgc_oe", 32'(lgc_pwm_oe), VECS[i].e_lgc ? 32'hF : 32'd0);
      check("R3", "lgc_o", 32'(lgc_pwm_o), 32'd0);
      check("R4", "aux_sdout", 32'(aux_sdout), 32'd0);
      check("R5", "aux_lrck", 32'(aux_lrck), 32'(VECS[i].e_lrck));
      check("R5", "aux_sclk", 32'(aux_sclk), 32'(VECS[i].e_sclk));
      check("R6", "dly_sdout", 32'(dly_sdout), 32'(VECS[i].e_dly));
    end
    aux_lrck_in = 1'b1; aux_sclk_in = 1'b1; hiz_sel = 1'b1;

    // R10: many idle cycles with flags toggling keep power-down
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      sclk_ok = i[0]; dly_cfg = i[1:0]; aux_en = i[2];
    end
    @(negedge clk);
    check_down("R10");

    // R7: exact start-up length and quiet PWM, then R8 run
    set_all_pass();
    aux_sdout_in = 1'b1; dly_sdout_in = 1'b0; ser_sdata = 1'b1;
    write_pd(1'b0);
    for (int i = 0; i < SU; i++) begin
      check("R7", "pwr_oe", 32'(pwr_pwm_oe), 32'hF);
      check("R7", "pwr_o", 32'(pwr_pwm_o), 32'd0);
      check("R7", "lgc_o", 32'(lgc_pwm_o), 32'd0);
      check("R7", "aux_sdout", 32'(aux_sdout), 32'd1);
      check("R7", "dly_sdout", 32'(dly_sdout), 32'd0);
      @(negedge clk);
    end
    check("R8", "pwr_o", 32'(pwr_pwm_o), 32'hF);
    check("R8", "lgc_o", 32'(lgc_pwm_o), 32'hF);
    check("R8", "lgc_oe", 32'(lgc_pwm_oe), 32'hF);
    pwr_pwm_in = 4'b1010; lgc_pwm_in = 4'b0110;
    aux_sdout_in = 1'b0; aux_lrck_in = 1'b0; aux_sclk_in = 1'b1; dly_sdout_in = 1'b1;
    aux_en = 1'b0;
    #1;
    check("R8", "pwr_o pattern", 32'(pwr_pwm_o), 32'hA);
    check("R8", "lgc_o pattern", 32'(lgc_pwm_o), 32'h6);
    check("R8", "aux", 32'({aux_sdout, aux_lrck, aux_sclk, dly_sdout}), 32'h3);

    // R10: run persists through flag changes without a write
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      sclk_ok = i[0]; adc_src = i[1];
    end
    check("R10", "run hold pwr_o", 32'(pwr_pwm_o), 32'hA);

    // R9: power-down from run lands on the write edge
    hiz_sel = 1'b0;
    write_pd(1'b1);
    check_down("R9");

    // R9: power-down during start-up
    hiz_sel = 1'b1; pwr_pwm_in = '1;
    write_pd(1'b0);
    repeat (3) @(negedge clk);
    check("R7", "mid start-up oe", 32'(pwr_pwm_oe), 32'hF);
    write_pd(1'b1);
    check_down("R9");

    // R7: start-up restarts from full length after an abort
    write_pd(1'b0);
    repeat (SU - 1) @(negedge clk);
    check("R7", "last start-up cycle", 32'(pwr_pwm_o), 32'd0);
    @(negedge clk);
    check("R8", "first run cycle", 32'(pwr_pwm_o), 32'hF);

    // R1: reset mid-run returns to power-down
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_down("R1");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule